// File: doc/BRIEF.md
# Command Ring Queue with Refill Requests

This block is a small circular queue of command words sitting between a host bus and a downstream transfer engine. The host pushes 32-bit commands, each with byte enables. The transfer engine takes the entry at the head of the queue whenever the queue presents it, and pulses a completion strobe to remove it. Entries stay in fixed storage slots. A read index and an occupancy count track the queue. No write pointer is stored: the push slot is the read index plus the count, wrapped by the depth. Both the index and the count are visible as status.

When refill is enabled and the queue has a free slot, the block asks for more commands. A route bit sends the request either to an interrupt line or to a DMA request line. Two sticky flags record errors. The first is overflow: a push was attempted while the queue was full. The second is underflow: the queue was empty while the surrounding logic held it in the triggered state. Each flag has its own clear strobe.

Top module: `cmd_ring_fifo`

## Requirements
- R1: After a synchronous reset, count and rd_idx are 0, xfer_valid is low, and uflow_flag and ovfl_flag are low.
- R2: An accepted push writes slot (rd_idx + count) mod DEPTH. Entries reach xfer_data in the order they were pushed, and each push raises count by one on the next clock edge.
- R3: When xfer_done is high while xfer_valid is high, the head entry is removed. count falls by one, and rd_idx advances by one, wrapping from DEPTH-1 to 0.
- R4: If an accepted push and a removal happen in the same cycle, count is unchanged, rd_idx advances, and the new word joins the tail of the queue.
- R5: A push while count equals DEPTH is discarded, even if a removal happens in the same cycle. It sets ovfl_flag, which stays high until an ovfl_clr cycle. count never exceeds DEPTH.
- R6: A refill request is raised only while fill_en is high and count is below DEPTH. dma_sel=0 drives refill_irq and dma_sel=1 drives refill_dma. Both lines are never high together, and both are low when the queue is full.
- R7: xfer_valid is high exactly when triggered is high, count is nonzero and uflow_flag is low. xfer_data shows the entry at rd_idx.
- R8: uflow_flag is set at any clock edge where triggered is high and count is 0. It is never set while triggered is low. It stays high until a uflow_clr cycle, and a set condition in the same cycle wins over the clear.
- R9: push_be bit k enables byte k (bits 8k+7..8k) of push_data. Bytes that are not enabled are stored as zero, and the push still takes a full slot.
- R10: xfer_done while xfer_valid is low changes neither count nor rd_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Push strobe from the host bus |
| push_data | input | DATA_W | Command word to push |
| push_be | input | DATA_W/8 | Byte enables for push_data |
| xfer_done | input | 1 | Transfer engine has consumed the head entry |
| triggered | input | 1 | Queue is in the triggered state |
| fill_en | input | 1 | Enables refill requests |
| dma_sel | input | 1 | Refill route: 0 interrupt, 1 DMA |
| uflow_clr | input | 1 | Clear strobe for uflow_flag |
| ovfl_clr | input | 1 | Clear strobe for ovfl_flag |
| xfer_valid | output | 1 | Head entry is offered for transfer |
| xfer_data | output | DATA_W | Entry at rd_idx |
| rd_idx | output | $clog2(DEPTH) | Transfer-side read index |
| count | output | $clog2(DEPTH+1) | Number of stored entries |
| refill_irq | output | 1 | Refill request routed to the interrupt line |
| refill_dma | output | 1 | Refill request routed to the DMA line |
| uflow_flag | output | 1 | Sticky underflow status |
| ovfl_flag | output | 1 | Sticky overflow status |

## Verification
The bench uses the default build, DATA_W=32 and DEPTH=4. With only four slots, a handful of pushes fills the queue, so the dropped-push path and the silent refill lines at full are cheap to reach. The same small depth lets a short run of removals carry rd_idx from 3 back to 0 while slots are reused. A partial byte-enable push placed right after an underflow checks both the zero fill and the rule that the flag holds the head entry back until it is cleared.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  // Destination of a refill request
  typedef enum logic {
    ROUTE_IRQ = 1'b0,
    ROUTE_DMA = 1'b1
  } refill_route_e;
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   wbe,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slots [DEPTH];
  logic [DATA_W-1:0] merged;

  // Bytes without an enable are written as zero
  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    assign merged[8*b +: 8] = wbe[b] ? wdata[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= merged;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/cmdq_ptrs.sv
module cmdq_ptrs #(
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             full,
  output logic             empty,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] wr_idx,
  output logic [CNT_W-1:0] count
);
  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_req && !full;
  // Push slot derived from read index plus occupancy (power-of-two wrap)
  assign wr_idx  = rd_idx + count[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (pop_req) rd_idx <= rd_idx + 1'b1;
      case ({push_ok, pop_req})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cmdq_flags.sv
module cmdq_flags (
  input  logic clk,
  input  logic rst,
  input  logic triggered,
  input  logic empty,
  input  logic push_drop,
  input  logic uflow_clr,
  input  logic ovfl_clr,
  output logic uflow_flag,
  output logic ovfl_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      uflow_flag <= 1'b0;
      ovfl_flag  <= 1'b0;
    end else begin
      if (triggered && empty) uflow_flag <= 1'b1;
      else if (uflow_clr)     uflow_flag <= 1'b0;
      if (push_drop)          ovfl_flag  <= 1'b1;
      else if (ovfl_clr)      ovfl_flag  <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdq_req.sv
module cmdq_req
  import cmdq_pkg::*;
(
  input  logic fill_en,
  input  logic dma_sel,
  input  logic full,
  output logic refill_irq,
  output logic refill_dma
);
  refill_route_e route;
  logic          want;

  assign route      = refill_route_e'(dma_sel);
  assign want       = fill_en && !full;
  assign refill_irq = want && (route == ROUTE_IRQ);
  assign refill_dma = want && (route == ROUTE_DMA);
endmodule

// File: rtl/cmd_ring_fifo.sv
module cmd_ring_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  input  logic [BE_W-1:0]   push_be,
  input  logic              xfer_done,
  input  logic              triggered,
  input  logic              fill_en,
  input  logic              dma_sel,
  input  logic              uflow_clr,
  input  logic              ovfl_clr,
  output logic              xfer_valid,
  output logic [DATA_W-1:0] xfer_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  count,
  output logic              refill_irq,
  output logic              refill_dma,
  output logic              uflow_flag,
  output logic              ovfl_flag
);
  logic             push_ok, full, empty, pop;
  logic [IDX_W-1:0] wr_idx;

  assign xfer_valid = triggered && !empty && !uflow_flag;
  assign pop        = xfer_done && xfer_valid;

  cmdq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push_req(push_en), .pop_req(pop),
    .push_ok(push_ok), .full(full), .empty(empty),
    .rd_idx(rd_idx), .wr_idx(wr_idx), .count(count)
  );

  cmdq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push_ok), .waddr(wr_idx), .wdata(push_data),
    .wbe(push_be), .raddr(rd_idx), .rdata(xfer_data)
  );

  cmdq_flags u_flags (
    .clk(clk), .rst(rst), .triggered(triggered), .empty(empty),
    .push_drop(push_en && full), .uflow_clr(uflow_clr), .ovfl_clr(ovfl_clr),
    .uflow_flag(uflow_flag), .ovfl_flag(ovfl_flag)
  );

  cmdq_req u_req (
    .fill_en(fill_en), .dma_sel(dma_sel), .full(full),
    .refill_irq(refill_irq), .refill_dma(refill_dma)
  );
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             push_en,
  input logic             xfer_done,
  input logic             triggered,
  input logic             uflow_clr,
  input logic             xfer_valid,
  input logic [IDX_W-1:0] rd_idx,
  input logic [CNT_W-1:0] count,
  input logic             refill_irq,
  input logic             refill_dma,
  input logic             uflow_flag,
  input logic             ovfl_flag
);
  a_r3_pop_advances: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && xfer_valid) |=> rd_idx == IDX_W'($past(rd_idx) + 1'b1));
  a_r3_pop_count: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && xfer_valid && !push_en) |=> count == CNT_W'($past(count) - 1'b1));
  a_r4_pushpop_stable: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && xfer_valid && push_en && count != CNT_W'(DEPTH)) |=> $stable(count));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  a_r5_overflow_set: assert property (@(posedge clk) disable iff (rst)
    (push_en && count == CNT_W'(DEPTH)) |=> ovfl_flag);
  a_r6_one_route: assert property (@(posedge clk) disable iff (rst)
    $onehot0({refill_irq, refill_dma}));
  a_r6_quiet_full: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(DEPTH)) |-> !(refill_irq || refill_dma));
  a_r7_valid_cond: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> (triggered && count != '0 && !uflow_flag));
  a_r8_underflow_set: assert property (@(posedge clk) disable iff (rst)
    (triggered && count == '0) |=> uflow_flag);
  a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (uflow_flag && !uflow_clr) |=> uflow_flag);
  a_r10_idle_done: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !xfer_valid && !push_en) |=> ($stable(count) && $stable(rd_idx)));
endmodule

bind cmd_ring_fifo cmdq_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_cmd_ring_fifo.sv
`timescale 1ns/1ps
module tb_cmd_ring_fifo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_en = 1'b0, xfer_done = 1'b0, triggered = 1'b0;
  logic        fill_en = 1'b0, dma_sel = 1'b0, uflow_clr = 1'b0, ovfl_clr = 1'b0;
  logic [31:0] push_data = '0;
  logic [3:0]  push_be = '0;
  logic        xfer_valid, refill_irq, refill_dma, uflow_flag, ovfl_flag;
  logic [31:0] xfer_data;
  logic [1:0]  rd_idx;
  logic [2:0]  count;

  int errs = 0, checks = 0, mcount = 0, midx = 0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  cmd_ring_fifo dut (.*);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask(input logic [31:0] d, input logic [3:0] be);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = d[8*b +: 8];
    return m;
  endfunction

  // Driver: pushes and records the expected item
  task automatic drive_push(input logic [31:0] d, input logic [3:0] be);
    push_en = 1'b1; push_data = d; push_be = be;
    tick;
    push_en = 1'b0;
    if (mcount < 4) begin exp_q.push_back(mask(d, be)); mcount++; end
    chk(count == 3'(mcount), "R2 count after push", 32'(count), 32'(mcount));
  endtask

  // Monitor: compares the head entry with the scoreboard and removes it
  task automatic take_head(input string req);
    chk(xfer_valid == 1'b1, {req, " valid"}, 32'(xfer_valid), 1);
    chk(xfer_data == exp_q[0], {req, " data"}, xfer_data, exp_q[0]);
    xfer_done = 1'b1;
    tick;
    xfer_done = 1'b0;
    void'(exp_q.pop_front());
    mcount--; midx = (midx + 1) % 4;
    chk(rd_idx == 2'(midx), "R3 index advance", 32'(rd_idx), 32'(midx));
    chk(count == 3'(mcount), "R3 count drop", 32'(count), 32'(mcount));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst = 1'b0;
    tick;
    // R1 reset state
    chk(count == 0 && rd_idx == 0, "R1 count/index", {count, rd_idx}, 0);
    chk(!xfer_valid && !uflow_flag && !ovfl_flag, "R1 valid/flags",
        {xfer_valid, uflow_flag, ovfl_flag}, 0);

    // R6 routing
    fill_en = 1'b1; dma_sel = 1'b0; #1;
    chk(refill_irq && !refill_dma, "R6 irq route", {refill_irq, refill_dma}, 2'b10);
    dma_sel = 1'b1; #1;
    chk(!refill_irq && refill_dma, "R6 dma route", {refill_irq, refill_dma}, 2'b01);

    // R2 fill while not triggered; R7 no valid
    drive_push(32'hA0A0_0001, 4'hF);
    drive_push(32'hA0A0_0002, 4'hF);
    drive_push(32'hA0A0_0003, 4'hF);
    drive_push(32'hA0A0_0004, 4'hF);
    chk(!xfer_valid, "R7 not triggered", 32'(xfer_valid), 0);
    chk(!refill_irq && !refill_dma, "R6 full quiet", {refill_irq, refill_dma}, 0);

    // R5 overflow
    drive_push(32'hDEAD_BEEF, 4'hF);
    chk(ovfl_flag, "R5 overflow set", 32'(ovfl_flag), 1);
    tick;
    chk(ovfl_flag, "R5 overflow sticky", 32'(ovfl_flag), 1);
    ovfl_clr = 1'b1; tick; ovfl_clr = 1'b0;
    chk(!ovfl_flag, "R5 overflow clear", 32'(ovfl_flag), 0);

    // R2/R3 drain with wrap
    triggered = 1'b1; #1;
    take_head("R2 order");
    take_head("R2 order");
    drive_push(32'hB0B0_0005, 4'hF);
    drive_push(32'hB0B0_0006, 4'hF);
    for (int i = 0; i < 4; i++) take_head("R3 wrap");
    chk(!uflow_flag, "R8 not yet set", 32'(uflow_flag), 0);

    // R8 underflow while triggered and empty
    tick;
    chk(uflow_flag, "R8 underflow set", 32'(uflow_flag), 1);
    drive_push(32'h1122_3344, 4'b0101);
    chk(!xfer_valid, "R7 held by underflow", 32'(xfer_valid), 0);
    uflow_clr = 1'b1; tick; uflow_clr = 1'b0;
    chk(!uflow_flag, "R8 clear", 32'(uflow_flag), 0);
    chk(xfer_data == 32'h0022_0044, "R9 zero fill", xfer_data, 32'h0022_0044);

    // R10 done with no valid entry
    triggered = 1'b0;
    xfer_done = 1'b1; tick; xfer_done = 1'b0;
    chk(count == 1 && rd_idx == 2'(midx), "R10 no effect", {count, rd_idx}, {3'd1, 2'(midx)});

    // R4 push and removal together
    triggered = 1'b1; #1;
    chk(xfer_data == exp_q[0], "R4 head data", xfer_data, exp_q[0]);
    push_en = 1'b1; push_data = 32'hC0C0_0007; push_be = 4'hF; xfer_done = 1'b1;
    tick;
    push_en = 1'b0; xfer_done = 1'b0;
    void'(exp_q.pop_front()); exp_q.push_back(32'hC0C0_0007); midx = (midx + 1) % 4;
    chk(count == 1, "R4 count held", 32'(count), 1);
    chk(rd_idx == 2'(midx), "R4 index moved", 32'(rd_idx), 32'(midx));
    take_head("R4 new tail");

    // R8 no set while not triggered, then sticky
    triggered = 1'b0;
    tick;
    chk(!uflow_flag, "R8 untriggered", 32'(uflow_flag), 0);
    triggered = 1'b1; tick; triggered = 1'b0; tick;
    chk(uflow_flag, "R8 sticky", 32'(uflow_flag), 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule